// File: doc/BRIEF.md
# MIDI Host Port Register Interface

This block connects a host I/O bus to a serial MIDI line. It answers to two neighbouring I/O addresses. The lower address carries MIDI data in both directions. The upper address takes commands on a write and gives back status on a read. Bytes the host writes to the data address wait in a 16-entry queue, and a built-in 8N1 transmitter sends them out at the MIDI bit rate. Bytes that arrive on the serial input go into a 16-entry receive queue, and the host reads them back from the data address.

The controller works only as a plain UART. Commands are not interpreted. Each command write instead places a fixed acknowledge byte in the receive queue, in arrival order with the serial traffic, and the controller keeps the low six bits of the command for the status register. A level interrupt tells the host that receive data is waiting. A read of the data address clears it, and it comes back on the next clock if bytes remain.

Top module: `midi_host_port`

## Requirements
- R1: An access hits only when address bits above bit 9 are all zero and bits 9:1 match the base (default 0x330). Bit 0 selects data (0) or command/status (1). An access that misses has no effect.
- R2: A write to the data address puts the byte into a 16-entry transmit queue. A write while that queue is full is discarded.
- R3: The serial output idles high and sends each queued byte in write order. Each frame is one low start bit, eight data bits LSB first and one high stop bit. Every bit lasts CLKS_PER_BIT clocks (31.25 kbaud at the default).
- R4: The receiver samples each bit at mid-bit and stores every frame with a high stop bit into a 16-entry receive queue. A frame whose stop bit is low is dropped.
- R5: Every write to the command address puts the byte 0xFE into the receive queue and records bits 5:0 of the written value.
- R6: A status read returns bit 7 = 1 when the receive queue is empty, bit 6 = 1 when the transmit queue is full, and bits 5:0 = the last recorded command bits. After reset the status reads 0x80.
- R7: A read of the data address removes the oldest received byte. The value of any read appears on the read-data output from the clock after the read strobe and holds until the next read.
- R8: A data read while the receive queue is empty returns the last byte taken from the queue and leaves the queue unchanged.
- R9: When a command write and a received serial byte arrive in the same cycle, 0xFE is queued first and the serial byte on a following cycle. Neither is lost.
- R10: The interrupt rises one clock after the receive queue becomes non-empty. It is low in the clock after a data read, and it rises again on the next clock if the queue is still not empty.
- R11: After reset the interrupt is low and the serial output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W (16) | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid from the clock after the strobe |
| irq | output | 1 | Receive-data interrupt, active high |
| midi_out | output | 1 | Serial MIDI output |
| midi_in | input | 1 | Serial MIDI input |

## Verification
The hardest case to reach from the ports is a command write that lands in the exact cycle in which the receiver finishes a frame. The host cannot see that cycle directly. To reach it, the stimulus sends a serial frame and issues a command write at every clock offset in a window around the stop bit. Each offset is checked to return exactly 0xFE and the serial byte and then an empty queue. At the two ends of the window, the order of the two bytes must flip from acknowledge-first to serial-first.

// File: rtl/midi_pkg.sv
package midi_pkg;
  localparam logic [7:0] ACK_BYTE = 8'hFE;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;
endpackage

// File: rtl/midi_byte_fifo.sv
module midi_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == LAST_IDX) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == LAST_IDX) ? '0 : rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full) else $error("push into full queue changed it"); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty) else $error("pop from empty queue changed it"); // R8
endmodule

// File: rtl/midi_uart_tx.sv
module midi_uart_tx #(
  parameter int CLKS_PER_BIT = 1600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] data,
  output logic       busy,
  output logic       line
);
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [9:0]    sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    bit_q, bit_d;
  logic          busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, data, 1'b0};
        cnt_d  = '0;
        bit_d  = '0;
      end
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
      if (bit_q == 4'd9) begin
        busy_d = 1'b0;
      end else begin
        bit_d = bit_q + 4'd1;
        sh_d  = {1'b1, sh_q[9:1]};
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign line = busy_q ? sh_q[0] : 1'b1;

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line) else $error("serial line low while idle"); // R3
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !line)) else $error("frame did not open with start bit"); // R3
endmodule

// File: rtl/midi_uart_rx.sv
module midi_uart_rx
  import midi_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line,
  output logic       valid,
  output logic [7:0] data
);
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2 - 1);

  rx_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic          valid_q, valid_d;
  logic          s1_q, s2_q;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    valid_d = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (!s2_q) begin
          st_d  = RX_START;
          cnt_d = '0;
        end
      end
      RX_START: begin
        if (cnt_q == HALF) begin
          cnt_d = '0;
          bit_d = '0;
          st_d  = s2_q ? RX_IDLE : RX_DATA;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_DATA: begin
        if (cnt_q == LAST) begin
          cnt_d = '0;
          sh_d  = {s2_q, sh_q[7:1]};
          if (bit_q == 3'd7) st_d = RX_STOP;
          else               bit_d = bit_q + 3'd1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (cnt_q == LAST) begin
          cnt_d = '0;
          if (s2_q) begin
            valid_d = 1'b1;
            st_d    = RX_IDLE;
          end else begin
            st_d = RX_BREAK;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_BREAK: begin
        if (s2_q) st_d = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      valid_q <= valid_d;
      s1_q    <= line;
      s2_q    <= s1_q;
    end
  end

  assign valid = valid_q;
  assign data  = sh_q;

  AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid) else $error("receive strobe longer than one cycle"); // R4
  AST_RX_BAD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_BREAK) |-> !valid) else $error("byte delivered from broken frame"); // R4
endmodule

// File: rtl/midi_host_port.sv
module midi_host_port
  import midi_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          DEC_W        = 10,
  parameter logic [9:0]  BASE_ADDR    = 10'h330,
  parameter int          FIFO_DEPTH   = 16,
  parameter int          CLKS_PER_BIT = 1600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              irq,
  output logic              midi_out,
  input  logic              midi_in
);
  localparam int UPPER_W = ADDR_W - DEC_W;

  logic       rs1_q, rst_i;
  logic       base_hit, tx_push, cmd_wr, data_rd, stat_rd;
  logic       tx_empty, tx_full, tx_busy, tx_start;
  logic [7:0] tx_head;
  logic       rx_empty, rx_full, rx_push, rx_pop;
  logic [7:0] rx_head, rx_push_data;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       stash_v_q, stash_v_d;
  logic [7:0] stash_q, stash_d;
  logic [5:0] cmd_q, cmd_d;
  logic [7:0] rdata_q, rdata_d, last_q, last_d;
  logic       irq_q, irq_d;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_i <= rs1_q;
    end
  end

  // 10-bit decode with zero upper bits
  assign base_hit = (io_addr[ADDR_W-1:DEC_W] == UPPER_W'(0)) &&
                    (io_addr[DEC_W-1:1] == BASE_ADDR[DEC_W-1:1]);
  assign tx_push  = io_wr && base_hit && !io_addr[0];
  assign cmd_wr   = io_wr && base_hit &&  io_addr[0];
  assign data_rd  = io_rd && base_hit && !io_addr[0];
  assign stat_rd  = io_rd && base_hit &&  io_addr[0];
  assign rx_pop   = data_rd && !rx_empty;
  assign tx_start = !tx_busy && !tx_empty;

  midi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_tx_fifo (
    .clk(clk), .rst_n(rst_i), .push(tx_push), .wdata(io_wdata),
    .pop(tx_start), .rdata(tx_head), .empty(tx_empty), .full(tx_full)
  );

  midi_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_i), .start(tx_start), .data(tx_head),
    .busy(tx_busy), .line(midi_out)
  );

  midi_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst_n(rst_i), .line(midi_in), .valid(rx_valid), .data(rx_byte)
  );

  midi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
    .clk(clk), .rst_n(rst_i), .push(rx_push), .wdata(rx_push_data),
    .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full)
  );

  // receive-queue merge: acknowledge wins, a clashing serial byte waits a cycle
  always_comb begin
    rx_push      = 1'b0;
    rx_push_data = rx_byte;
    stash_v_d    = stash_v_q;
    stash_d      = stash_q;
    if (cmd_wr) begin
      rx_push      = 1'b1;
      rx_push_data = ACK_BYTE;
      if (rx_valid) begin
        stash_v_d = 1'b1;
        stash_d   = rx_byte;
      end
    end else if (stash_v_q) begin
      rx_push      = 1'b1;
      rx_push_data = stash_q;
      stash_v_d    = rx_valid;
      if (rx_valid) stash_d = rx_byte;
    end else if (rx_valid) begin
      rx_push = 1'b1;
    end
  end

  // host-visible registers
  always_comb begin
    cmd_d   = cmd_wr ? io_wdata[5:0] : cmd_q;
    last_d  = rx_pop ? rx_head : last_q;
    rdata_d = rdata_q;
    if (data_rd)      rdata_d = rx_empty ? last_q : rx_head;
    else if (stat_rd) rdata_d = {rx_empty, tx_full, cmd_q};
    irq_d   = data_rd ? 1'b0 : !rx_empty;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      stash_v_q <= 1'b0;
      stash_q   <= '0;
      cmd_q     <= '0;
      last_q    <= '0;
      rdata_q   <= '0;
      irq_q     <= 1'b0;
    end else begin
      stash_v_q <= stash_v_d;
      stash_q   <= stash_d;
      cmd_q     <= cmd_d;
      last_q    <= last_d;
      rdata_q   <= rdata_d;
      irq_q     <= irq_d;
    end
  end

  assign io_rdata = rdata_q;
  assign irq      = irq_q;

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_i)
    data_rd |=> !irq) else $error("interrupt not cleared by data read"); // R10
  AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_i)
    irq |-> !rx_empty) else $error("interrupt with empty receive queue"); // R10
  AST_ACK_QUEUED: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd_wr && !rx_full) |=> !rx_empty) else $error("command write left queue empty"); // R5
  AST_STASH_DRAIN: assert property (@(posedge clk) disable iff (!rst_i)
    (stash_v_q && !cmd_wr && !rx_valid) |=> !stash_v_q) else $error("held serial byte not drained"); // R9
  AST_CMD_BITS: assert property (@(posedge clk) disable iff (!rst_i)
    cmd_wr |=> (cmd_q == $past(io_wdata[5:0]))) else $error("command bits not recorded"); // R6
endmodule

// File: tb/midi_host_port_test.sv
module midi_host_port_test;
  localparam int          CPB  = 16;
  localparam logic [15:0] BASE = 16'h0330;
  localparam logic [15:0] CMDA = 16'h0331;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        irq, midi_out;
  logic        midi_in = 1'b1;

  int n_run = 0, n_fail = 0;
  logic [7:0] tx_log [64];
  int tx_cnt = 0, tx_badstop = 0;
  logic [5:0] last_cmd = '0;

  always #10 clk = ~clk;

  midi_host_port #(.CLKS_PER_BIT(CPB)) uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .irq(irq),
    .midi_out(midi_out), .midi_in(midi_in)
  );

  function automatic logic [7:0] exp_status(bit rxe, bit txf, logic [5:0] c);
    return {rxe, txf, c};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic send_frame(logic [7:0] b, bit stop_ok);
    @(negedge clk);
    midi_in = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      midi_in = b[i];
      repeat (CPB) @(negedge clk);
    end
    midi_in = stop_ok;
    repeat (CPB) @(negedge clk);
    midi_in = 1'b1;
    repeat (2 * CPB) @(negedge clk);
  endtask

  // serial output decoder, samples at mid-bit on the falling clock
  initial begin
    forever begin
      logic [7:0] b;
      @(negedge midi_out);
      repeat (CPB / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (CPB) @(negedge clk);
        b[i] = midi_out;
      end
      repeat (CPB) @(negedge clk);
      if (!midi_out) tx_badstop++;
      if (tx_cnt < 64) tx_log[tx_cnt] = b;
      tx_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    logic [7:0] bytes [20];
    int start;
    void'($urandom(32'h1A2B3C4D));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 / R6: reset state
    check("R11 irq after reset", {7'd0, irq}, 8'h00);
    check("R11 midi_out after reset", {7'd0, midi_out}, 8'h01);
    io_read(CMDA, d);
    check("R6 status after reset", d, exp_status(1, 0, 6'h00));

    // R5 / R6 / R10 / R7: command write acknowledge
    io_write(CMDA, 8'hC5);
    last_cmd = 6'h05;
    @(negedge clk);
    check("R10 irq after ack", {7'd0, irq}, 8'h01);
    io_read(CMDA, d);
    check("R6 status with data", d, exp_status(0, 0, last_cmd));
    io_read(BASE, d);
    check("R5 ack byte", d, 8'hFE);
    check("R10 irq cleared", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R10 irq stays low when empty", {7'd0, irq}, 8'h00);
    check("R7 rdata held", io_rdata, 8'hFE);

    // R8: empty read returns last byte taken
    io_read(BASE, d);
    check("R8 empty read value", d, 8'hFE);
    io_read(CMDA, d);
    check("R8 queue still empty", d, exp_status(1, 0, last_cmd));

    // R1: aliases and neighbours have no effect
    start = tx_cnt;
    io_write(16'h0730, 8'h55);
    io_write(16'h0731, 8'h3F);
    io_write(16'h8331, 8'h3F);
    io_write(16'h0332, 8'h11);
    io_write(16'h0333, 8'h22);
    repeat (12 * CPB) @(negedge clk);
    check("R1 no frame from miss", 8'(tx_cnt - start), 8'h00);
    io_read(CMDA, d);
    check("R1 status unchanged", d, exp_status(1, 0, last_cmd));

    // R10: re-raise while data remains
    io_write(CMDA, 8'h2A);
    io_write(CMDA, 8'h6B);
    last_cmd = 6'h2B;
    io_read(BASE, d);
    check("R10 irq low after read", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R10 irq re-raised", {7'd0, irq}, 8'h01);
    io_read(BASE, d);
    @(negedge clk);
    check("R10 irq low once drained", {7'd0, irq}, 8'h00);

    // R3: random transmit bytes
    start = tx_cnt;
    for (int i = 0; i < 8; i++) begin
      bytes[i] = 8'($urandom_range(0, 255));
      io_write(BASE, bytes[i]);
    end
    repeat (10 * 10 * CPB) @(negedge clk);
    check("R3 frame count", 8'(tx_cnt - start), 8'd8);
    for (int i = 0; i < 8; i++) check("R3 tx byte", tx_log[start + i], bytes[i]);
    check("R3 stop bits high", 8'(tx_badstop), 8'h00);

    // R2: fill the transmit queue, overflow discarded
    start = tx_cnt;
    for (int i = 0; i < 18; i++) begin
      bytes[i] = 8'($urandom_range(0, 255));
      io_write(BASE, bytes[i]);
    end
    io_read(CMDA, d);
    check("R2 tx full flag", d, exp_status(1, 1, last_cmd));
    repeat (19 * 10 * CPB) @(negedge clk);
    check("R2 overflow dropped", 8'(tx_cnt - start), 8'd17);
    for (int i = 0; i < 17; i++) check("R2 queued byte", tx_log[start + i], bytes[i]);
    io_read(CMDA, d);
    check("R2 tx not full after drain", d, exp_status(1, 0, last_cmd));

    // R4: random receive bytes
    for (int i = 0; i < 6; i++) begin
      bytes[i] = 8'($urandom_range(0, 255));
      send_frame(bytes[i], 1'b1);
    end
    check("R10 irq with rx data", {7'd0, irq}, 8'h01);
    for (int i = 0; i < 6; i++) begin
      io_read(BASE, d);
      check("R4 rx byte", d, bytes[i]);
    end
    io_read(CMDA, d);
    check("R4 rx drained", d, exp_status(1, 0, last_cmd));

    // R4: broken stop bit dropped
    send_frame(8'hA7, 1'b0);
    io_read(CMDA, d);
    check("R4 bad stop dropped", d, exp_status(1, 0, last_cmd));
    send_frame(8'h3C, 1'b1);
    io_read(BASE, d);
    check("R4 recovers after bad stop", d, 8'h3C);
    io_read(BASE, d);
    check("R8 empty read after rx", d, 8'h3C);

    // R9: command write swept across the end of a frame
    for (int off = 140; off <= 170; off++) begin
      logic [7:0] b;
      logic [7:0] cv;
      b  = 8'($urandom_range(0, 253));
      cv = 8'($urandom_range(0, 255));
      fork
        send_frame(b, 1'b1);
        begin
          repeat (off) @(negedge clk);
          io_addr = CMDA; io_wdata = cv; io_wr = 1'b1;
          @(negedge clk);
          io_wr = 1'b0;
        end
      join
      last_cmd = cv[5:0];
      io_read(BASE, d);
      io_read(BASE, d2);
      n_run++;
      if (!((d == 8'hFE && d2 == b) || (d == b && d2 == 8'hFE))) begin
        n_fail++;
        $display("FAIL R9 offset %0d: actual %02h %02h expected {FE,%02h}", off, d, d2, b);
      end
      if (off == 140) check("R9 early write ack first", d, 8'hFE);
      if (off == 170) check("R9 late write serial first", d, b);
      io_read(CMDA, d);
      check("R9 nothing extra queued", d, exp_status(1, 0, last_cmd));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule